// File: doc/BRIEF.md
# I2S Slave Audio Transmitter

This block sends audio samples over a serial audio link on which an external master supplies the bit clock and the word-select line. Software writes each 16-bit sample into a single-entry holding register through a valid/ready write port. At every channel boundary the sample moves from the holding register into a shift register. It then leaves the serial data pin MSB first, one bit per falling bit-clock edge, using the Philips framing: 16 data bits in a 16-bit channel, with the MSB one bit-clock after the word-select change.

The block must be enabled before the master starts clocking. The first sample must be written before the first word-select change. Software watches the buffer-empty flag to supply the next sample in time. If the holding register is still empty when a channel boundary arrives, the block records a sticky underrun, drives the data line low and stops transmitting. It stays stopped until software drops the enable and raises it again. An interrupt output reports the underrun when the error-interrupt enable is set. A channel flag shows which word-select level the current sample belongs to. Software may shut the block down once buffer-empty is high and busy is low.

The external bit clock and word-select pass through two-flop synchronizers into the system clock domain. The serial output settles about three system clocks after a bit-clock falling edge, so the system clock must run at least eight times faster than the bit clock.

Top module: `i2s_slave_tx`

## Requirements
- R1: While en_i is low, sd_o is 0, tbe_o is 1, busy_o, chan_o, urerr_o and wr_ready_o are 0, writes are not stored, and the bit clock has no effect.
- R2: wr_ready_o equals en_i AND tbe_o. A write with wr_valid_i high while wr_ready_o is high stores wr_data_i, and tbe_o reads 0 from the next cycle.
- R3: A word-select change is detected at a falling bit-clock edge. At the next falling edge the held sample is loaded and its bit 15 drives sd_o. Each later falling edge presents the next lower bit, so the external master captures the 16 bits MSB first on rising edges.
- R4: The load at a channel boundary sets tbe_o to 1 and raises busy_o, which stays high while the sample is shifted.
- R5: chan_o takes the word-select level that follows the change (0 = left, 1 = right) when the sample for that channel is loaded.
- R6: If tbe_o is 1 when a load is due, urerr_o becomes 1, busy_o and sd_o go to 0, and no further data is sent while en_i stays high. Writes are still accepted, but they do not clear urerr_o.
- R7: irq_o is 1 exactly while urerr_o is 1 and err_ie_i is 1.
- R8: Dropping en_i clears urerr_o. After en_i is raised again, transmission restarts normally at the next word-select change.
- R9: When the LSB has been sent and no word-select change has followed, busy_o falls to 0 and sd_o to 0 at the next falling edge.
- R10: The word-select level present at the first falling edge after enable is not treated as a change. No load happens until word-select actually toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| err_ie_i | input | 1 | Error interrupt enable |
| wr_valid_i | input | 1 | Sample write request |
| wr_data_i | input | 16 | Sample to transmit |
| wr_ready_o | output | 1 | Holding register can accept a sample |
| sck_i | input | 1 | Bit clock from the external master |
| ws_i | input | 1 | Word-select from the external master |
| sd_o | output | 1 | Serial data out |
| tbe_o | output | 1 | Holding register empty |
| busy_o | output | 1 | Shift register is sending a sample |
| chan_o | output | 1 | Channel of the sample being sent |
| urerr_o | output | 1 | Sticky transmit underrun flag |
| irq_o | output | 1 | Error interrupt |

## Verification
A wrong boundary or bit-count state shows up on sd_o within one bit-clock period as a shifted, truncated or repeated word. The master model catches it at its next rising-edge capture, and the per-clock reference comparison sees it three system clocks after the offending falling edge. A stale holding-register or halt state shows up on tbe_o, wr_ready_o or urerr_o at the very next clock. It also leaks a non-zero bit onto sd_o at the next channel boundary during an underrun.

// File: rtl/i2s_tx_pkg.sv
`timescale 1ns/1ps
package i2s_tx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_HALT  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/i2s_tx_sync.sv
`timescale 1ns/1ps
module i2s_tx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= '0;
      else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2s_tx_hold.sv
`timescale 1ns/1ps
module i2s_tx_hold #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_fire_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o
);
  logic [DW-1:0] data_q;
  logic          empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (!en_i) begin
      empty_q <= 1'b1;
    end else begin
      if (take_i) empty_q <= 1'b1;
      // a write in the same cycle as a failed load still fills the buffer
      if (wr_fire_i) begin
        data_q  <= wr_data_i;
        empty_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/i2s_tx_shift.sv
`timescale 1ns/1ps
module i2s_tx_shift
  import i2s_tx_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sck_i,
  input  logic          ws_i,
  input  logic          empty_i,
  input  logic [DW-1:0] hold_i,
  output logic          take_o,
  output logic          sd_o,
  output logic          busy_o,
  output logic          chan_o,
  output logic          urerr_o
);
  localparam int unsigned CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  tx_state_e     st_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          sck_d_q;
  logic          ws_prev_q;
  logic          ws_seen_q;
  logic          pend_q;
  logic          sd_q;
  logic          chan_q;

  logic fall, load_now;

  assign fall     = sck_d_q & ~sck_i;
  assign load_now = en_i & fall & pend_q & (st_q != TX_HALT);
  assign take_o   = load_now & ~empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= TX_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      ws_prev_q <= 1'b0;
      ws_seen_q <= 1'b0;
      pend_q    <= 1'b0;
      sd_q      <= 1'b0;
      chan_q    <= 1'b0;
    end else if (!en_i) begin
      st_q      <= TX_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      ws_prev_q <= 1'b0;
      ws_seen_q <= 1'b0;
      pend_q    <= 1'b0;
      sd_q      <= 1'b0;
      chan_q    <= 1'b0;
    end else if (fall && st_q != TX_HALT) begin
      if (pend_q) begin
        pend_q <= 1'b0;
        if (empty_i) begin
          st_q <= TX_HALT;
          sd_q <= 1'b0;
        end else begin
          st_q   <= TX_SHIFT;
          sh_q   <= hold_i;
          sd_q   <= hold_i[DW-1];
          cnt_q  <= LAST_IDX;
          chan_q <= ws_prev_q;
        end
      end else if (st_q == TX_SHIFT) begin
        if (cnt_q != '0) begin
          sh_q  <= {sh_q[DW-2:0], 1'b0};
          sd_q  <= sh_q[DW-2];
          cnt_q <= cnt_q - 1'b1;
        end else begin
          st_q <= TX_IDLE;
          sd_q <= 1'b0;
        end
      end
      // boundary seen now, MSB goes out on the following falling edge
      if (ws_seen_q && (ws_i != ws_prev_q)) pend_q <= 1'b1;
      ws_prev_q <= ws_i;
      ws_seen_q <= 1'b1;
    end
  end

  assign sd_o    = sd_q;
  assign busy_o  = (st_q == TX_SHIFT);
  assign chan_o  = chan_q;
  assign urerr_o = (st_q == TX_HALT);
endmodule

// File: rtl/i2s_slave_tx.sv
`timescale 1ns/1ps
module i2s_slave_tx #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              err_ie_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              sck_i,
  input  logic              ws_i,
  output logic              sd_o,
  output logic              tbe_o,
  output logic              busy_o,
  output logic              chan_o,
  output logic              urerr_o,
  output logic              irq_o
);
  logic [1:0]        pins_s;
  logic [DATA_W-1:0] hold_data;
  logic              empty, take, wr_fire, urerr;

  i2s_tx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ws_i, sck_i}),
    .q_o    (pins_s)
  );

  assign wr_ready_o = en_i & empty;
  assign wr_fire    = wr_valid_i & wr_ready_o;

  i2s_tx_hold #(.DW(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .wr_fire_i (wr_fire),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (hold_data),
    .empty_o   (empty)
  );

  i2s_tx_shift #(.DW(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .sck_i   (pins_s[0]),
    .ws_i    (pins_s[1]),
    .empty_i (empty),
    .hold_i  (hold_data),
    .take_o  (take),
    .sd_o    (sd_o),
    .busy_o  (busy_o),
    .chan_o  (chan_o),
    .urerr_o (urerr)
  );

  assign tbe_o   = empty;
  assign urerr_o = urerr;
  assign irq_o   = urerr & err_ie_i;
endmodule

// File: rtl/i2s_slave_tx_chk.sv
`timescale 1ns/1ps
module i2s_slave_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic err_ie_i,
  input logic wr_valid_i,
  input logic wr_ready_o,
  input logic sd_o,
  input logic tbe_o,
  input logic busy_o,
  input logic urerr_o,
  input logic irq_o
);
  p_quiet_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sd_o && tbe_o && !busy_o && !urerr_o));

  p_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o) |=> !tbe_o);

  p_load_empties_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> tbe_o);

  p_halt_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urerr_o |-> (!busy_o && !sd_o));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urerr_o && en_i) |=> urerr_o);

  p_irq_raise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(urerr_o) && err_ie_i) |-> irq_o);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !urerr_o);

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sd_o);
endmodule

bind i2s_slave_tx i2s_slave_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .err_ie_i   (err_ie_i),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .sd_o       (sd_o),
  .tbe_o      (tbe_o),
  .busy_o     (busy_o),
  .urerr_o    (urerr_o),
  .irq_o      (irq_o)
);

// File: tb/i2s_slave_tx_test.sv
`timescale 1ns/1ps
module i2s_slave_tx_test;
  localparam int DW = 16;
  localparam int H  = 8;  // bit-clock half period in system clocks

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, err_ie = 1'b0, wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic sck = 1'b1, ws = 1'b1;
  logic wr_ready, sd, tbe, busy, chan, urerr, irq;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] cap_q[$];
  logic          chan_q[$];

  always #2.5 clk = ~clk;

  i2s_slave_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .err_ie_i(err_ie),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .sck_i(sck), .ws_i(ws), .sd_o(sd), .tbe_o(tbe), .busy_o(busy),
    .chan_o(chan), .urerr_o(urerr), .irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_s1, m_s2, m_d, m_w1, m_w2;
  bit m_tbe = 1'b1, m_busy, m_sd, m_chan, m_ur, m_pend, m_wsv, m_wsp;
  int m_idx;
  logic [DW-1:0] m_word, m_hold;

  always @(posedge clk) begin
    bit fall, tbe_old, was_pend;
    if (!rst_n) begin
      m_tbe = 1'b1; m_busy = 0; m_sd = 0; m_chan = 0; m_ur = 0;
      m_pend = 0; m_wsv = 0; m_wsp = 0; m_idx = 0;
      m_s1 = 0; m_s2 = 0; m_d = 0; m_w1 = 0; m_w2 = 0;
    end else begin
      fall    = m_d && !m_s2;
      tbe_old = m_tbe;
      if (!en) begin
        m_tbe = 1'b1; m_busy = 0; m_sd = 0; m_chan = 0; m_ur = 0;
        m_pend = 0; m_wsv = 0; m_wsp = 0; m_idx = 0;
      end else begin
        if (fall && !m_ur) begin
          was_pend = m_pend;
          m_pend   = 0;
          if (was_pend) begin
            if (m_tbe) begin
              m_ur = 1; m_busy = 0; m_sd = 0;
            end else begin
              m_word = m_hold; m_idx = DW - 1; m_sd = m_word[m_idx];
              m_busy = 1; m_tbe = 1; m_chan = m_wsp;
            end
          end else if (m_busy) begin
            if (m_idx > 0) begin
              m_idx--; m_sd = m_word[m_idx];
            end else begin
              m_busy = 0; m_sd = 0;
            end
          end
          if (m_wsv && (m_w2 != m_wsp)) m_pend = 1;
          m_wsp = m_w2;
          m_wsv = 1;
        end
        if (wr_valid && tbe_old) begin
          m_hold = wr_data; m_tbe = 0;
        end
      end
      m_d = m_s2; m_s2 = m_s1; m_s1 = sck;
      m_w2 = m_w1; m_w1 = ws;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3", "model sd_o",       sd,       m_sd);
      check("R4", "model tbe_o",      tbe,      m_tbe);
      check("R4", "model busy_o",     busy,     m_busy);
      check("R5", "model chan_o",     chan,     m_chan);
      check("R6", "model urerr_o",    urerr,    m_ur);
      check("R7", "model irq_o",      irq,      m_ur & err_ie);
      check("R2", "model wr_ready_o", wr_ready, en & m_tbe);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_master(input int words, input int extra, input bit chk);
    logic [DW-1:0] cur = '0;
    int total = 2 + DW * words + extra;
    for (int n = 0; n < total; n++) begin
      @(negedge clk); #1;
      sck = 1'b0;
      if (n == 0) ws = 1'b1;
      else if (n >= 2 && n < 2 + DW * words && ((n - 2) % DW) == 0)
        ws = (((n - 2) / DW) % 2) != 0;
      repeat (H) @(negedge clk);
      #1;
      sck = 1'b1;
      if (chk && n == 2) check("R10", "busy before first load", busy, 1'b0);
      if (n >= 3 && n <= 2 + DW * words) begin
        int b = DW - 1 - ((n - 3) % DW);
        cur[b] = sd;
        if (b == DW - 1) begin
          chan_q.push_back(chan);
          if (chk) check("R4", "busy at MSB", busy, 1'b1);
        end
        if (b == 0) cap_q.push_back(cur);
      end
      repeat (H - 1) @(negedge clk);
    end
  endtask

  task automatic write_sample(input logic [DW-1:0] v);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      if (wr_ready) begin
        #1; wr_valid = 1'b1; wr_data = v;
        @(negedge clk); #1; wr_valid = 1'b0;
        done = 1;
      end
    end
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); #1; en = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset sd_o", sd, 1'b0);
    check("R1", "reset tbe_o", tbe, 1'b1);
    check("R1", "reset busy_o", busy, 1'b0);
    check("R1", "reset urerr_o", urerr, 1'b0);
    check("R1", "reset irq_o", irq, 1'b0);
    check("R1", "reset wr_ready_o", wr_ready, 1'b0);

    // disabled: clock and writes ignored
    #1; wr_valid = 1'b1; wr_data = 16'hDEAD;
    run_master(2, 2, 0);
    @(negedge clk); #1; wr_valid = 1'b0;
    @(negedge clk);
    check("R1", "tbe_o after disabled write", tbe, 1'b1);
    check("R1", "disabled word 0", cap_q[0], 16'h0000);
    check("R1", "disabled word 1", cap_q[1], 16'h0000);
    cap_q.delete(); chan_q.delete();

    // normal stream of four channels
    set_en(1'b1);
    write_sample(16'hA5C3);
    @(negedge clk);
    check("R2", "tbe_o after write", tbe, 1'b0);
    fork
      run_master(4, 3, 1);
      begin
        write_sample(16'h1234);
        write_sample(16'h8001);
        write_sample(16'h7FFE);
      end
    join
    @(negedge clk);
    check("R3", "word 0", cap_q[0], 16'hA5C3);
    check("R3", "word 1", cap_q[1], 16'h1234);
    check("R3", "word 2", cap_q[2], 16'h8001);
    check("R3", "word 3", cap_q[3], 16'h7FFE);
    check("R5", "chan word 0", chan_q[0], 1'b0);
    check("R5", "chan word 1", chan_q[1], 1'b1);
    check("R5", "chan word 2", chan_q[2], 1'b0);
    check("R5", "chan word 3", chan_q[3], 1'b1);
    check("R9", "busy_o after last word", busy, 1'b0);
    check("R9", "sd_o after last word", sd, 1'b0);
    check("R9", "tbe_o after last word", tbe, 1'b1);
    cap_q.delete(); chan_q.delete();

    // underrun
    set_en(1'b0);
    @(negedge clk); #1; err_ie = 1'b1;
    set_en(1'b1);
    write_sample(16'hC0DE);
    run_master(3, 2, 0);
    @(negedge clk);
    check("R6", "urerr_o after underrun", urerr, 1'b1);
    check("R7", "irq_o with enable", irq, 1'b1);
    check("R6", "busy_o after underrun", busy, 1'b0);
    check("R6", "word before underrun", cap_q[0], 16'hC0DE);
    check("R6", "word after underrun", cap_q[1], 16'h0000);
    check("R6", "second word after underrun", cap_q[2], 16'h0000);
    cap_q.delete(); chan_q.delete();
    #1; err_ie = 1'b0;
    @(negedge clk);
    check("R7", "irq_o masked", irq, 1'b0);
    write_sample(16'hFFFF);
    @(negedge clk);
    check("R6", "tbe_o after write in underrun", tbe, 1'b0);
    check("R6", "urerr_o kept after write", urerr, 1'b1);
    run_master(2, 2, 0);
    @(negedge clk);
    check("R6", "halted word 0", cap_q[0], 16'h0000);
    check("R6", "halted word 1", cap_q[1], 16'h0000);
    check("R6", "urerr_o still set", urerr, 1'b1);
    cap_q.delete(); chan_q.delete();

    // recovery by enable toggle
    set_en(1'b0);
    check("R8", "urerr_o after disable", urerr, 1'b0);
    #1; err_ie = 1'b1;
    set_en(1'b1);
    check("R8", "irq_o after re-enable", irq, 1'b0);
    write_sample(16'h0F0F);
    fork
      run_master(2, 3, 1);
      write_sample(16'hB00B);
    join
    @(negedge clk);
    check("R8", "resumed word 0", cap_q[0], 16'h0F0F);
    check("R8", "resumed word 1", cap_q[1], 16'hB00B);
    check("R8", "urerr_o after resume", urerr, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule